// File: doc/BRIEF.md
# Four-State Line Coherence Controller

This block holds the coherence state and tag of every line in a small direct-mapped cache. It serves one local processor port and one snooping port. For each local read or write it looks up the line, decides if a bus transaction is needed, raises it, and on grant writes the new line state. For each snooped transaction it answers the same cycle with wired-OR style response strobes and updates the line at the clock edge. The four states are Invalid, Shared, Exclusive and Modified. Data arrays, memory and arbitration sit outside. Data movement appears only as strobes.

A processor raises `cpu_req` with `cpu_we` and `cpu_addr` and holds them until `cpu_done` pulses. `cpu_state` then reports the state the line ended in. The bus side holds `bus_req`, `bus_op` and `bus_addr` until `bus_gnt`. At grant the bus samples `bus_shared_in` (another cache holds the block) and `bus_retry_in` (another cache blocked the request). An address is `{tag, index}`, with the index in the low bits.

Top module: `mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid, so a snoop read of any address gives no response and the first local read of any address issues a bus read.
- R2: A local read that hits a valid line completes with no bus request and reports the unchanged state.
- R3: A local read miss issues bus op 0 (read). At grant the line fills as Exclusive (state code 2) when `bus_shared_in` is low, and as Shared (code 1) when it is high.
- R4: A local write hit on Exclusive completes with no bus request and ends Modified (code 3). A write hit on Modified stays Modified with no bus request.
- R5: A local write hit on Shared first issues bus op 2 (invalidate) for the line address. The line becomes Modified at grant.
- R6: A local write miss issues bus op 1 (read with intent to modify). The line ends Modified.
- R7: A snoop read (type 0) that hits Exclusive or Modified raises `snp_supply` and `snp_shared`, and the line becomes Shared. A hit on Modified also raises `snp_wb`.
- R8: A snoop of type 1 (read with intent to modify) or type 2 (invalidate) that hits Shared or Exclusive makes the line Invalid, with no response strobe.
- R9: A snoop of type 1 that hits Modified raises `snp_retry` and `snp_wb`, and the line becomes Invalid.
- R10: A snoop that hits the index of a pending local request is applied first. The request drops its bus request and looks the line up again.
- R11: A grant with `bus_retry_in` high completes nothing. The request looks the line up again and reissues its transaction.
- R12: A miss whose victim line is Modified first issues bus op 3 (write-back) at the victim's address, then the fill transaction.
- R13: A snoop read that hits any valid line raises `snp_shared`. A Shared line raises no supply strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Local access request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Local address {tag, index} |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_state | output | 2 | Final line state (0 I, 1 S, 2 E, 3 M), valid with cpu_done |
| bus_req | output | 1 | Bus transaction request |
| bus_op | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr | output | 12 | Transaction address |
| bus_gnt | input | 1 | Transaction granted and completed |
| bus_shared_in | input | 1 | Another cache holds the block (sampled at grant) |
| bus_retry_in | input | 1 | Transaction blocked, retry (sampled at grant) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_type | input | 2 | 0 read, 1 read-for-ownership, 2 invalidate |
| snp_addr | input | 12 | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy (snoop read) |
| snp_supply | output | 1 | This cache supplies the block; requester abandons memory |
| snp_retry | output | 1 | Requester must retry |
| snp_wb | output | 1 | This cache writes the block back to memory |

## Verification
The hardest case to reach is a snoop that lands on the same line while a local request waits for its grant. To create it, the bench holds back the grant on a pending invalidate for a Shared line and drives a read-for-ownership snoop to that address in that cycle. It then expects the request to turn into a read-for-ownership. Dirty-victim eviction needs a second tag that maps to the index of a Modified line. A retried grant needs `bus_retry_in` raised together with the first grant only.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BOP_READ = 2'd0, BOP_RFO = 2'd1, BOP_INV = 2'd2, BOP_WB = 2'd3} bus_op_t;
  typedef enum logic [1:0] {SN_READ = 2'd0, SN_RFO = 2'd1, SN_INV = 2'd2, SN_NONE = 2'd3} snp_kind_t;
endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_t         a_st,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_t         b_st,
  output logic [TAG_W-1:0] b_tag,
  input  logic             s_we,
  input  logic [IDX_W-1:0] s_idx,
  input  line_st_t         s_st,
  input  logic             c_we,
  input  logic [IDX_W-1:0] c_idx,
  input  line_st_t         c_st,
  input  logic [TAG_W-1:0] c_tag
);
  line_st_t         st_v  [LINES];
  logic [TAG_W-1:0] tag_v [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t         st_q, st_d;
    logic [TAG_W-1:0] tg_q, tg_d;
    logic             en;

    always_comb begin
      st_d = st_q;
      tg_d = tg_q;
      if (c_we && c_idx == IDX_W'(g)) begin
        st_d = c_st;
        tg_d = c_tag;
      end
      // snoop update wins on a shared index
      if (s_we && s_idx == IDX_W'(g)) st_d = s_st;
      en = (st_d != st_q) || (tg_d != tg_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= ST_I;
        tg_q <= '0;
      end else if (en) begin
        st_q <= st_d;
        tg_q <= tg_d;
      end
    end

    assign st_v[g]  = st_q;
    assign tag_v[g] = tg_q;
  end

  assign a_st  = st_v[a_idx];
  assign a_tag = tag_v[a_idx];
  assign b_st  = st_v[b_idx];
  assign b_tag = tag_v[b_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             valid,
  input  snp_kind_t        kind,
  input  logic [TAG_W-1:0] tag,
  input  line_st_t         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             hit,
  output logic             upd,
  output line_st_t         new_st,
  output logic             shared,
  output logic             supply,
  output logic             retry,
  output logic             wb
);
  always_comb begin
    hit    = valid && (line_st != ST_I) && (line_tag == tag);
    upd    = 1'b0;
    new_st = line_st;
    shared = 1'b0;
    supply = 1'b0;
    retry  = 1'b0;
    wb     = 1'b0;
    if (hit) begin
      unique case (kind)
        SN_READ: begin
          shared = 1'b1;
          if (line_st == ST_E || line_st == ST_M) begin
            supply = 1'b1;
            wb     = (line_st == ST_M);
            upd    = 1'b1;
            new_st = ST_S;
          end
        end
        SN_RFO: begin
          upd    = 1'b1;
          new_st = ST_I;
          if (line_st == ST_M) begin
            retry = 1'b1;
            wb    = 1'b1;
          end
        end
        SN_INV: begin
          upd    = 1'b1;
          new_st = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 4,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output line_st_t          cpu_state,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_st_t          lk_st,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              conflict,
  output logic              bus_req,
  output bus_op_t           bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              bus_retry_in,
  output logic              wr_en,
  output line_st_t          wr_st,
  output logic [TAG_W-1:0]  wr_tag
);
  typedef enum logic [1:0] {FS_IDLE, FS_LOOK, FS_BUS} fs_t;

  fs_t               fs_q, fs_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  bus_op_t           op_q, op_d;
  logic              done_q, done_d;
  line_st_t          dst_q, dst_d;
  logic [TAG_W-1:0]  rq_tag;
  logic              hit;

  assign rq_tag = addr_q[ADDR_W-1:IDX_W];
  assign lk_idx = addr_q[IDX_W-1:0];
  assign hit    = (lk_st != ST_I) && (lk_tag == rq_tag);

  always_comb begin
    fs_d   = fs_q;
    we_d   = we_q;
    addr_d = addr_q;
    op_d   = op_q;
    done_d = 1'b0;
    dst_d  = dst_q;
    wr_en  = 1'b0;
    wr_st  = ST_I;
    wr_tag = rq_tag;
    unique case (fs_q)
      FS_IDLE: if (cpu_req) begin
        we_d   = cpu_we;
        addr_d = cpu_addr;
        fs_d   = FS_LOOK;
      end
      FS_LOOK: if (!conflict) begin
        if (hit && !we_q) begin
          done_d = 1'b1; dst_d = lk_st; fs_d = FS_IDLE;
        end else if (hit && lk_st == ST_S) begin
          op_d = BOP_INV; fs_d = FS_BUS;
        end else if (hit) begin
          wr_en  = (lk_st == ST_E);
          wr_st  = ST_M;
          done_d = 1'b1; dst_d = ST_M; fs_d = FS_IDLE;
        end else if (lk_st == ST_M) begin
          op_d = BOP_WB; fs_d = FS_BUS;
        end else begin
          op_d = we_q ? BOP_RFO : BOP_READ; fs_d = FS_BUS;
        end
      end
      FS_BUS: begin
        if (conflict || (bus_gnt && bus_retry_in)) begin
          fs_d = FS_LOOK;
        end else if (bus_gnt) begin
          wr_en = 1'b1;
          if (op_q == BOP_WB) begin
            wr_st  = ST_I;
            wr_tag = lk_tag;
            fs_d   = FS_LOOK;
          end else begin
            wr_st  = (op_q == BOP_READ) ? (bus_shared_in ? ST_S : ST_E) : ST_M;
            done_d = 1'b1;
            dst_d  = wr_st;
            fs_d   = FS_IDLE;
          end
        end
      end
      default: fs_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= FS_IDLE;
      we_q   <= 1'b0;
      addr_q <= '0;
      op_q   <= BOP_READ;
      done_q <= 1'b0;
      dst_q  <= ST_I;
    end else begin
      fs_q   <= fs_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      op_q   <= op_d;
      done_q <= done_d;
      dst_q  <= dst_d;
    end
  end

  assign cpu_done  = done_q;
  assign cpu_state = dst_q;
  assign bus_req   = (fs_q == FS_BUS);
  assign bus_op    = op_q;
  assign bus_addr  = (op_q == BOP_WB) ? {lk_tag, lk_idx} : addr_q;
endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic [1:0]        cpu_state,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              bus_retry_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_type,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic              snp_retry,
  output logic              snp_wb
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [IDX_W-1:0] lk_idx;
  line_st_t         lk_st, sn_st, sn_new, wr_st, dst;
  logic [TAG_W-1:0] lk_tag, sn_tag, wr_tag;
  logic             sn_hit, sn_upd, wr_en, conflict;
  bus_op_t          op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  mesi_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_sync_n),
    .a_idx(lk_idx), .a_st(lk_st), .a_tag(lk_tag),
    .b_idx(snp_addr[IDX_W-1:0]), .b_st(sn_st), .b_tag(sn_tag),
    .s_we(sn_upd), .s_idx(snp_addr[IDX_W-1:0]), .s_st(sn_new),
    .c_we(wr_en), .c_idx(lk_idx), .c_st(wr_st), .c_tag(wr_tag)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .valid(snp_valid), .kind(snp_kind_t'(snp_type)), .tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_st(sn_st), .line_tag(sn_tag),
    .hit(sn_hit), .upd(sn_upd), .new_st(sn_new),
    .shared(snp_shared), .supply(snp_supply), .retry(snp_retry), .wb(snp_wb)
  );

  assign conflict = sn_hit && (snp_addr[IDX_W-1:0] == lk_idx);

  mesi_req_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .cpu_state(dst),
    .lk_idx(lk_idx), .lk_st(lk_st), .lk_tag(lk_tag), .conflict(conflict),
    .bus_req(bus_req), .bus_op(op), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .bus_retry_in(bus_retry_in),
    .wr_en(wr_en), .wr_st(wr_st), .wr_tag(wr_tag)
  );

  assign cpu_state = dst;
  assign bus_op    = op;
endmodule

// File: rtl/mesi_ctrl_chk.sv
module mesi_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic              cpu_done,
  input logic [1:0]        cpu_state,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_op,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_type,
  input logic              snp_supply,
  input logic              snp_shared,
  input logic              snp_retry,
  input logic              snp_wb
);
  // R6
  write_ends_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_we |-> cpu_state == 2'd3);

  // R3
  read_ends_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && !cpu_we |-> cpu_state != 2'd0);

  // R7
  supply_implies_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared);

  // R9
  retry_implies_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> snp_wb && snp_type == 2'd1);

  // R7
  wb_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb |-> snp_valid && snp_type != 2'd2);

  // R11
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !snp_valid |=> bus_req && $stable(bus_op) && $stable(bus_addr));
endmodule

bind mesi_ctrl mesi_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_we(cpu_we), .cpu_done(cpu_done),
  .cpu_state(cpu_state), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_op(bus_op),
  .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_type(snp_type),
  .snp_supply(snp_supply), .snp_shared(snp_shared), .snp_retry(snp_retry), .snp_wb(snp_wb)
);

// File: tb/test_mesi_ctrl.sv
module test_mesi_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic        cpu_done;
  logic [1:0]  cpu_state;
  logic        bus_req;
  logic [1:0]  bus_op;
  logic [11:0] bus_addr;
  logic        bus_gnt = 1'b0, bus_shared_in = 1'b0, bus_retry_in = 1'b0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_type = '0;
  logic [11:0] snp_addr = '0;
  logic        snp_shared, snp_supply, snp_retry, snp_wb;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  mesi_ctrl i_mesi_ctrl (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // local access; answers each bus request with a grant, optional retry or snoop injection
  task automatic access(input string req, input bit we, input logic [11:0] a, input bit sh,
                        input bit rty, input bit inj, input int nops, input int op0,
                        input int op1, input logic [11:0] a0, input int exp_st);
    int  k = 0;
    bit  fin = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    for (int c = 0; c < 40 && !fin; c++) begin
      @(negedge clk);
      bus_gnt = 1'b0; bus_shared_in = 1'b0; bus_retry_in = 1'b0; snp_valid = 1'b0;
      if (cpu_done) begin
        chk(req, "final state", int'(cpu_state), exp_st);
        fin = 1;
      end else if (bus_req) begin
        chk(req, "bus op", int'(bus_op), (k == 0) ? op0 : op1);
        if (k == 0) chk(req, "bus addr", int'(bus_addr), int'(a0));
        if (k == 0 && inj) begin
          snp_valid = 1'b1; snp_type = 2'd1; snp_addr = a;
        end else begin
          bus_gnt = 1'b1; bus_shared_in = sh; bus_retry_in = (k == 0) && rty;
        end
        k++;
      end
    end
    cpu_req = 1'b0;
    chk(req, "completed", int'(fin), 1);
    chk(req, "bus op count", k, nops);
  endtask

  task automatic snoop(input string req, input int t, input logic [11:0] a,
                       input bit es, input bit esup, input bit ert, input bit ewb);
    @(negedge clk);
    snp_valid = 1'b1; snp_type = 2'(t); snp_addr = a;
    #1;
    chk(req, "snp_shared", int'(snp_shared), int'(es));
    chk(req, "snp_supply", int'(snp_supply), int'(esup));
    chk(req, "snp_retry", int'(snp_retry), int'(ert));
    chk(req, "snp_wb", int'(snp_wb), int'(ewb));
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "bus_req after reset", int'(bus_req), 0);
    chk("R1", "cpu_done after reset", int'(cpu_done), 0);
    snoop("R1", 0, 12'h011, 0, 0, 0, 0);
    access("R1", 0, 12'h011, 0, 0, 0, 1, 0, 0, 12'h011, 2);
  endtask

  task automatic t_local_hits;
    access("R2", 0, 12'h011, 0, 0, 0, 0, 0, 0, 12'h000, 2);
    access("R4", 1, 12'h011, 0, 0, 0, 0, 0, 0, 12'h000, 3);
    access("R4", 1, 12'h011, 0, 0, 0, 0, 0, 0, 12'h000, 3);
  endtask

  task automatic t_snoop_mod;
    snoop("R7", 0, 12'h011, 1, 1, 0, 1);
    access("R7", 0, 12'h011, 0, 0, 0, 0, 0, 0, 12'h000, 1);
    access("R5", 1, 12'h011, 0, 0, 0, 1, 2, 0, 12'h011, 3);
    snoop("R9", 1, 12'h011, 0, 0, 1, 1);
    snoop("R9", 0, 12'h011, 0, 0, 0, 0);
  endtask

  task automatic t_fill_and_inval;
    access("R3", 0, 12'h022, 1, 0, 0, 1, 0, 0, 12'h022, 1);
    snoop("R8", 2, 12'h022, 0, 0, 0, 0);
    snoop("R8", 0, 12'h022, 0, 0, 0, 0);
    access("R8", 0, 12'h044, 0, 0, 0, 1, 0, 0, 12'h044, 2);
    snoop("R8", 1, 12'h044, 0, 0, 0, 0);
    access("R8", 0, 12'h044, 0, 0, 0, 1, 0, 0, 12'h044, 2);
    access("R7", 0, 12'h077, 0, 0, 0, 1, 0, 0, 12'h077, 2);
    snoop("R7", 0, 12'h077, 1, 1, 0, 0);
    access("R7", 1, 12'h077, 0, 0, 0, 1, 2, 0, 12'h077, 3);
  endtask

  task automatic t_write_miss_evict;
    access("R6", 1, 12'h033, 0, 0, 0, 1, 1, 0, 12'h033, 3);
    access("R12", 0, 12'h133, 0, 0, 0, 2, 3, 0, 12'h033, 2);
  endtask

  task automatic t_retry;
    access("R11", 0, 12'h055, 0, 1, 0, 2, 0, 0, 12'h055, 2);
  endtask

  task automatic t_priority;
    access("R13", 0, 12'h066, 1, 0, 0, 1, 0, 0, 12'h066, 1);
    snoop("R13", 0, 12'h066, 1, 0, 0, 0);
    access("R10", 1, 12'h066, 0, 0, 1, 2, 2, 1, 12'h066, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_local_hits();
    t_snoop_mod();
    t_fill_and_inval();
    t_write_miss_evict();
    t_retry();
    t_priority();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule